// File: doc/BRIEF.md
# Resampler Timing NCO Controller

This block is the timing oscillator behind a sample-rate converter. A 56-bit phase accumulator advances by a programmable frequency word, and its overflow carry tells the downstream filter that a new resampled output is due. The accumulated phase, with the carry, is what the interpolation stage uses to pick its coefficient position.

A host programs the frequency word through a small write-only register port. The word is split across two writes into a shadow register. It takes effect only when it is committed to the active register, either by a write to a dedicated commit address or by an external sync pulse. The sync path lets several channels switch frequency on the same clock edge.

The accumulator has two modes. In frequency-shift mode it accumulates normally and changes the effective sample rate. In phase-shift mode it ignores its own feedback, so the output is a fixed offset taken from the top five bits of the frequency word. Control bits can also zero the feedback on each commit or permanently, and can force the carry. A filter sequencer supplies two single-cycle step pulses, one at the start of an instruction and one at the last tap of an output. A control bit chooses which of the two advances the accumulator.

Top module: `rs_timing_nco`

## Requirements
- R1: After reset the phase output is zero, the carry is low, the active frequency is zero and every control bit is clear.
- R2: A write to address 0 loads shadow bits 55:24 from data bits 31:0. A write to address 1 loads shadow bits 23:0 from data bits 31:8 and ignores data bits 7:0. Shadow writes alone do not change the active frequency.
- R3: A write to address 2 copies the shadow word into the active frequency register on that clock edge.
- R4: When control bit 0 (sync enable) is set, a one-cycle pulse on `sync_in` commits the shadow word. When the bit is clear, the pulse has no effect.
- R5: A sync pulse and a commit write in the same cycle produce one commit. A commit always takes the shadow value held before that cycle's host write.
- R6: When control bit 2 is 1 (frequency-shift mode), each selected step sets phase to (phase + frequency) mod 2^56. If that sum overflows, the carry is high for exactly the one cycle after the step.
- R7: When control bit 2 is 0 (phase-shift mode), each selected step sets phase bits 55:51 to frequency bits 55:51 and clears all lower bits. No natural carry is produced.
- R8: When control bit 3 (force carry) is set, every selected step raises the carry for one cycle, whatever the mode.
- R9: When control bit 4 (clear on load) is set, a commit without a step in the same cycle sets phase to zero. When the bit is clear, a commit leaves the phase unchanged.
- R10: While control bit 5 (zero feedback) is set in frequency-shift mode, each step sets phase to the active frequency and produces no natural carry.
- R11: Control bit 1 set selects `step_start` as the step and ignores `step_last`. Control bit 1 clear selects `step_last` and ignores `step_start`.
- R12: Without a selected step or a clearing commit, the phase holds and the carry stays low.
- R13: Address 3 loads the control bits from data bits 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write enable, one cycle per write |
| host_addr | input | 2 | Host register address: 0 upper freq, 1 lower freq, 2 commit, 3 control |
| host_wdata | input | 32 | Host write data |
| sync_in | input | 1 | External commit pulse, synchronous to clk |
| step_start | input | 1 | Sequencer pulse at the start of a filter instruction |
| step_last | input | 1 | Sequencer pulse at the last tap of an output |
| phase_o | output | 56 | Accumulator phase |
| carry_o | output | 1 | One-cycle carry pulse after a step |

## Verification
The assertions assume that `step_start`, `step_last` and `sync_in` are synchronous single-cycle pulses, and that every host write is one cycle long. Under these assumptions, each step and each commit can be matched to exactly one clock edge. The bench changes inputs only on falling edges and holds each pulse for one cycle. It reads the active frequency indirectly: it sets frequency-shift mode with zero feedback, steps once, and reads the resulting phase. Coincident strobe and sync, and a shadow write in the same cycle as a sync, are driven deliberately so that the commit value is pinned to the shadow held before that edge.

// File: rtl/rs_nco_pkg.sv
package rs_nco_pkg;

    localparam int FREQ_W = 56;
    localparam int BUS_W  = 32;
    localparam int PSEL_W = 5;
    localparam int ADDR_W = 2;
    localparam int CTRL_W = 6;

    typedef enum logic [ADDR_W-1:0] {
        ADR_FREQ_HI = 2'd0,
        ADR_FREQ_LO = 2'd1,
        ADR_COMMIT  = 2'd2,
        ADR_CTRL    = 2'd3
    } reg_addr_e;

    // packed MSB first: sync_en lands on bit 0
    typedef struct packed {
        logic fb_zero;
        logic clr_on_load;
        logic force_carry;
        logic freq_mode;
        logic step_at_start;
        logic sync_en;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(input logic [BUS_W-1:0] w);
        return ctrl_t'(w[CTRL_W-1:0]);
    endfunction

    // phase-shift increment: top bits kept, rest cleared
    function automatic logic [FREQ_W-1:0] phase_offset(input logic [FREQ_W-1:0] f);
        return {f[FREQ_W-1 -: PSEL_W], {(FREQ_W-PSEL_W){1'b0}}};
    endfunction

endpackage

// File: rtl/rs_nco_regs.sv
module rs_nco_regs
    import rs_nco_pkg::*;
#(
    parameter int FW = FREQ_W,
    parameter int BW = BUS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BW-1:0]     wdata,
    output logic [FW-1:0]     shadow,
    output ctrl_t             ctrl,
    output logic              strobe
);
    localparam int LO_W = FW - BW;

    reg_addr_e        sel;
    logic [BW-1:0]    hi_q;
    logic [LO_W-1:0]  lo_q;
    ctrl_t            ctrl_q;

    assign sel    = reg_addr_e'(addr);
    assign strobe = we && (sel == ADR_COMMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q   <= '0;
            lo_q   <= '0;
            ctrl_q <= '0;
        end else if (we) begin
            case (sel)
                ADR_FREQ_HI: hi_q   <= wdata;
                ADR_FREQ_LO: lo_q   <= wdata[BW-1 -: LO_W];
                ADR_CTRL:    ctrl_q <= ctrl_from_word(wdata);
                default:     ;
            endcase
        end
    end

    assign shadow = {hi_q, lo_q};
    assign ctrl   = ctrl_q;

    a_r2_hi_keeps_lo: assert property (@(posedge clk) disable iff (rst)
        (we && sel == ADR_FREQ_HI) |=> $stable(shadow[LO_W-1:0]));
    a_r2_lo_keeps_hi: assert property (@(posedge clk) disable iff (rst)
        (we && sel == ADR_FREQ_LO) |=> $stable(shadow[FW-1:LO_W]));

endmodule

// File: rtl/rs_nco_commit.sv
module rs_nco_commit
    import rs_nco_pkg::*;
#(
    parameter int FW = FREQ_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    input  logic          sync_in,
    input  logic          sync_en,
    input  logic [FW-1:0] shadow,
    output logic [FW-1:0] freq_act,
    output logic          commit
);
    logic [FW-1:0] act_q;

    // strobe and sync merge into one commit event
    assign commit = strobe || (sync_in && sync_en);

    always_ff @(posedge clk) begin
        if (rst)         act_q <= '0;
        else if (commit) act_q <= shadow;
    end

    assign freq_act = act_q;

    a_r3_commit_takes_shadow: assert property (@(posedge clk) disable iff (rst)
        commit |=> (freq_act == $past(shadow)));
    a_r4_no_commit_holds: assert property (@(posedge clk) disable iff (rst)
        (!strobe && !(sync_in && sync_en)) |=> $stable(freq_act));

endmodule

// File: rtl/rs_nco_accum.sv
module rs_nco_accum
    import rs_nco_pkg::*;
#(
    parameter int FW = FREQ_W,
    parameter int PW = PSEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step_start,
    input  logic          step_last,
    input  ctrl_t         ctrl,
    input  logic [FW-1:0] freq_act,
    input  logic          commit,
    output logic [FW-1:0] phase,
    output logic          carry
);
    logic          step;
    logic          clr_load;
    logic          fb_off;
    logic [FW-1:0] fb;
    logic [FW-1:0] inc;
    logic [FW:0]   sum_ext;
    logic [FW-1:0] acc_q;
    logic          carry_q;

    assign step     = ctrl.step_at_start ? step_start : step_last;
    assign clr_load = commit && ctrl.clr_on_load;
    assign fb_off   = !ctrl.freq_mode || ctrl.fb_zero || clr_load;
    assign fb       = fb_off ? '0 : acc_q;
    assign inc      = ctrl.freq_mode ? freq_act : phase_offset(freq_act);
    assign sum_ext  = {1'b0, fb} + {1'b0, inc};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            carry_q <= step && (sum_ext[FW] || ctrl.force_carry);
            if (step)          acc_q <= sum_ext[FW-1:0];
            else if (clr_load) acc_q <= '0;
        end
    end

    assign phase = acc_q;
    assign carry = carry_q;

    a_r6_carry_needs_step: assert property (@(posedge clk) disable iff (rst)
        carry |-> $past(step));
    a_r7_phase_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
        (step && !ctrl.freq_mode) |=> (phase[FW-PW-1:0] == '0));
    a_r8_forced_carry: assert property (@(posedge clk) disable iff (rst)
        (step && ctrl.force_carry) |=> carry);
    a_r10_zero_feedback: assert property (@(posedge clk) disable iff (rst)
        (step && ctrl.freq_mode && ctrl.fb_zero && !ctrl.force_carry)
            |=> (phase == $past(freq_act) && !carry));
    a_r12_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!step && !clr_load) |=> ($stable(phase) && !carry));
    a_r9_clear_on_commit: assert property (@(posedge clk) disable iff (rst)
        (clr_load && !step) |=> (phase == '0));

endmodule

// File: rtl/rs_timing_nco.sv
module rs_timing_nco
    import rs_nco_pkg::*;
#(
    parameter int FW = FREQ_W,
    parameter int BW = BUS_W,
    parameter int PW = PSEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [BW-1:0]     host_wdata,
    input  logic              sync_in,
    input  logic              step_start,
    input  logic              step_last,
    output logic [FW-1:0]     phase_o,
    output logic              carry_o
);
    logic [FW-1:0] shadow;
    logic [FW-1:0] freq_act;
    ctrl_t         ctrl;
    logic          strobe;
    logic          commit;

    rs_nco_regs #(.FW(FW), .BW(BW)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (host_we),
        .addr   (host_addr),
        .wdata  (host_wdata),
        .shadow (shadow),
        .ctrl   (ctrl),
        .strobe (strobe)
    );

    rs_nco_commit #(.FW(FW)) u_commit (
        .clk      (clk),
        .rst      (rst),
        .strobe   (strobe),
        .sync_in  (sync_in),
        .sync_en  (ctrl.sync_en),
        .shadow   (shadow),
        .freq_act (freq_act),
        .commit   (commit)
    );

    rs_nco_accum #(.FW(FW), .PW(PW)) u_accum (
        .clk        (clk),
        .rst        (rst),
        .step_start (step_start),
        .step_last  (step_last),
        .ctrl       (ctrl),
        .freq_act   (freq_act),
        .commit     (commit),
        .phase      (phase_o),
        .carry      (carry_o)
    );

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> (phase_o == '0 && !carry_o));

endmodule

// File: tb/rs_timing_nco_tb.sv
module rs_timing_nco_tb;

    localparam int FW = 56;
    localparam logic [31:0] C_SYNC = 32'h01, C_START = 32'h02, C_FMODE = 32'h04,
                            C_FCARRY = 32'h08, C_CLR = 32'h10, C_FZERO = 32'h20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_we = 1'b0;
    logic [1:0]    host_addr = '0;
    logic [31:0]   host_wdata = '0;
    logic          sync_in = 1'b0;
    logic          step_start = 1'b0;
    logic          step_last = 1'b0;
    logic [FW-1:0] phase_o;
    logic          carry_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rs_timing_nco u_dut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .sync_in(sync_in), .step_start(step_start),
        .step_last(step_last), .phase_o(phase_o), .carry_o(carry_o)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_phase(input string tag, input logic [FW-1:0] exp);
        check(phase_o == exp, tag, {8'h0, phase_o}, {8'h0, exp});
    endtask

    task automatic check_carry(input string tag, input logic exp);
        check(carry_o == exp, tag, {63'h0, carry_o}, {63'h0, exp});
    endtask

    // one cycle of stimulus, applied at a falling edge; results readable at the next one
    task automatic cyc(input logic we, input logic [1:0] a, input logic [31:0] d,
                       input logic sy, input logic ss, input logic sl);
        @(negedge clk);
        host_we = we; host_addr = a; host_wdata = d;
        sync_in = sy; step_start = ss; step_last = sl;
        @(negedge clk);
        host_we = 1'b0; sync_in = 1'b0; step_start = 1'b0; step_last = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic set_freq(input logic [31:0] hi, input logic [31:0] lo);
        wr(2'd0, hi);
        wr(2'd1, lo);
        wr(2'd2, 32'h0);
    endtask

    // reads the active frequency through the phase output
    task automatic probe(input string tag, input logic [FW-1:0] exp);
        wr(2'd3, C_FMODE | C_FZERO | C_START);
        cyc(1'b0, 2'd0, 32'h0, 1'b0, 1'b1, 1'b0);
        check_phase(tag, exp);
    endtask

    task automatic t_reset;
        check_phase("R1 phase after reset", '0);
        check_carry("R1 carry after reset", 1'b0);
        probe("R1 active freq zero after reset", '0);
    endtask

    task automatic t_shadow_commit;
        wr(2'd0, 32'h1234_5678);
        wr(2'd1, 32'h9ABC_DEFF);
        probe("R2 shadow writes do not reach active", '0);
        wr(2'd2, 32'h0);
        probe("R3 commit strobe, R2 low byte ignored", 56'h12345678_9ABCDE);
    endtask

    task automatic t_sync;
        wr(2'd0, 32'h0000_0001);
        wr(2'd1, 32'h0);
        cyc(1'b0, 2'd0, 32'h0, 1'b1, 1'b0, 1'b0);
        probe("R4 sync ignored when disabled", 56'h12345678_9ABCDE);
        wr(2'd3, C_SYNC);
        cyc(1'b0, 2'd0, 32'h0, 1'b1, 1'b0, 1'b0);
        probe("R13 R4 sync commits when enabled", 56'h00000001_000000);
    endtask

    task automatic t_coincident;
        wr(2'd0, 32'h0000_0002);
        wr(2'd3, C_SYNC);
        cyc(1'b1, 2'd2, 32'h0, 1'b1, 1'b0, 1'b0);
        probe("R5 strobe with sync commits once", 56'h00000002_000000);
        wr(2'd3, C_SYNC);
        cyc(1'b1, 2'd0, 32'hAAAA_0000, 1'b1, 1'b0, 1'b0);
        probe("R5 sync takes shadow before same-cycle write", 56'h00000002_000000);
        wr(2'd2, 32'h0);
        probe("R5 later strobe takes new shadow", 56'hAAAA0000_000000);
    endtask

    task automatic t_freq_mode;
        set_freq(32'h4000_0000, 32'h0);
        probe("R6 preset phase", 56'h40000000_000000);
        wr(2'd3, C_FMODE | C_START);
        cyc(1'b0, 2'd0, 32'h0, 1'b0, 1'b1, 1'b0);
        check_phase("R6 accumulate step 2", 56'h80000000_000000);
        check_carry("R6 no carry without overflow", 1'b0);
        cyc(1'b0, 2'd0, 32'h0, 1'b0, 1'b1, 1'b0);
        check_phase("R6 accumulate step 3", 56'hC0000000_000000);
        cyc(1'b0, 2'd0, 32'h0, 1'b0, 1'b1, 1'b0);
        check_phase("R6 wrap to zero", '0);
        check_carry("R6 carry on overflow", 1'b1);
        @(negedge clk);
        check_carry("R6 carry lasts one cycle", 1'b0);
    endtask

    task automatic t_phase_mode;
        set_freq(32'hFFFF_FFFF, 32'hFFFF_FF00);
        wr(2'd3, C_START);
        cyc(1'b0, 2'd0, 32'h0, 1'b0, 1'b1, 1'b0);
        check_phase("R7 phase offset from top bits", 56'hF8000000_000000);
        check_carry("R7 no natural carry", 1'b0);
        cyc(1'b0, 2'd0, 32'h0, 1'b0, 1'b1, 1'b0);
        check_phase("R7 offset constant on repeat", 56'hF8000000_000000);
        check_carry("R7 no carry on repeat", 1'b0);
    endtask

    task automatic t_force_carry;
        wr(2'd3, C_START | C_FCARRY);
        cyc(1'b0, 2'd0, 32'h0, 1'b0, 1'b1, 1'b0);
        check_carry("R8 forced carry in phase mode", 1'b1);
        @(negedge clk);
        check_carry("R8 forced carry one cycle", 1'b0);
    endtask

    task automatic t_clear_on_load;
        wr(2'd3, C_FMODE | C_START | C_CLR);
        wr(2'd0, 32'h0);
        wr(2'd1, 32'h0000_1000);
        check_phase("R9 phase before commit", 56'hF8000000_000000);
        wr(2'd2, 32'h0);
        check_phase("R9 commit clears phase", '0);
        cyc(1'b0, 2'd0, 32'h0, 1'b0, 1'b1, 1'b0);
        check_phase("R9 first step after clear", 56'h10);
        cyc(1'b0, 2'd0, 32'h0, 1'b0, 1'b1, 1'b0);
        check_phase("R9 second step after clear", 56'h20);
        wr(2'd3, C_FMODE | C_START);
        wr(2'd2, 32'h0);
        check_phase("R9 commit without clear keeps phase", 56'h20);
    endtask

    task automatic t_force_zero;
        wr(2'd3, C_FMODE | C_START | C_FZERO);
        cyc(1'b0, 2'd0, 32'h0, 1'b0, 1'b1, 1'b0);
        check_phase("R10 zero feedback step 1", 56'h10);
        cyc(1'b0, 2'd0, 32'h0, 1'b0, 1'b1, 1'b0);
        check_phase("R10 zero feedback step 2", 56'h10);
        check_carry("R10 no carry", 1'b0);
    endtask

    task automatic t_step_select;
        wr(2'd3, C_FMODE | C_START);
        cyc(1'b0, 2'd0, 32'h0, 1'b0, 1'b0, 1'b1);
        check_phase("R11 step_last ignored in start select", 56'h10);
        cyc(1'b0, 2'd0, 32'h0, 1'b0, 1'b1, 1'b0);
        check_phase("R11 step_start advances", 56'h20);
        wr(2'd3, C_FMODE);
        cyc(1'b0, 2'd0, 32'h0, 1'b0, 1'b1, 1'b0);
        check_phase("R11 step_start ignored in last select", 56'h20);
        cyc(1'b0, 2'd0, 32'h0, 1'b0, 1'b0, 1'b1);
        check_phase("R11 step_last advances", 56'h30);
    endtask

    task automatic t_idle;
        repeat (5) @(negedge clk);
        check_phase("R12 phase holds when idle", 56'h30);
        check_carry("R12 carry low when idle", 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_shadow_commit();
        t_sync();
        t_coincident();
        t_freq_mode();
        t_phase_mode();
        t_force_carry();
        t_clear_on_load();
        t_force_zero();
        t_step_select();
        t_idle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule